// File: doc/BRIEF.md
# TV Audio Decoder Serial Control Port

This block is the two-wire serial slave through which a host configures a television sound decoder. A host addresses it, writes one control byte that sets the audio routing (decoding mode, forced mono, muting, external input, reference clock output, baseband input), or reads one status byte reporting what the broadcast detectors have found and whether the control register still holds its power-up value.

The serial clock and data lines are sampled by a fast system clock through a small synchroniser; start and stop conditions, bit timing and acknowledge are all recovered from those samples. The slave address is chosen by a three-way strap input, so three decoders can share one bus. A received byte takes effect only after the acknowledge clock of a complete transfer; a byte cut short, an unmatched address or a byte that would set a forbidden value leave the register untouched. The decoded control fields leave the block as registered outputs.

Top module: `tvsnd_i2c_ctrl`

## Requirements
- R1: The 7-bit slave address follows `adsel`: 2'b00 (strap floating) gives 7'h40, 2'b01 (strap high) gives 7'h42, 2'b10 (strap low) gives 7'h50, and 2'b11 is treated as floating (7'h40).
- R2: Bits are taken MSB first on rising serial clock edges; after the eighth bit of a matching address byte, and after the eighth bit of a write data byte, the slave pulls SDA low (`sda_pull` = 1) for the whole ninth clock.
- R3: `sda_pull` only changes while the synchronised serial clock is low.
- R4: After reset the register holds 8'h01: `mode_sel` = 2'b01 (main), and `force_mono`, `mute_on`, `ext_in_sel`, `refclk_en`, `baseband_sel` are 0. A completed write of byte b sets `mode_sel` = b[1:0], `force_mono` = b[2], `mute_on` = b[3], `ext_in_sel` = b[4], `refclk_en` = b[5], `baseband_sel` = b[6].
- R5: A stop condition that arrives before the eighth data bit discards the partial byte; all control outputs keep their previous values.
- R6: A written byte with b[7] = 1 (test) or b[1:0] = 2'b11 is acknowledged but not stored; the outputs keep their previous values and `mode_sel` never becomes 2'b11.
- R7: A read returns, MSB first, bit 7 = `stereo_det`, bit 6 = `biling_det`, bit 5 = power-on flag, bits 4..0 = 0, driven one bit per serial clock low phase.
- R8: The power-on flag is 1 after reset, clears on the first stored write, and does not return to 1 except by reset; a rejected write (R6) does not clear it.
- R9: When the address byte does not match, the slave never pulls SDA and ignores all bytes until the next start condition.
- R10: A start condition inside a transfer (repeated start) abandons it and restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (resolved bus) |
| adsel | input | 2 | Address strap: 00 floating, 01 high, 10 low, 11 as floating |
| stereo_det | input | 1 | Stereo broadcast detected |
| biling_det | input | 1 | Bilingual broadcast detected |
| sda_pull | output | 1 | 1 = drive SDA low (open drain), 0 = release |
| mode_sel | output | 2 | 00 bilingual, 01 main, 10 sub |
| force_mono | output | 1 | Force mono output |
| mute_on | output | 1 | Mute both outputs |
| ext_in_sel | output | 1 | Route external input to outputs |
| refclk_en | output | 1 | Enable reference clock output |
| baseband_sel | output | 1 | Take baseband input instead of sound IF |

## Verification
The bench walks writes through every strap setting, including the 2'b11 fallback, mixing stored bytes with bytes carrying the test bit or the forbidden mode code; a design that stored those would show the illegal mode or a cleared power-on flag on the next read. A byte cut off by a stop after five bits, and an address phase cut off by a repeated start, are aimed at designs that commit on the stop or keep counting bits across a restart. A host addressing another strap setting checks that a careless slave would neither acknowledge nor absorb the following byte, and status reads before and after the first stored write catch a flag that is cleared by any write or never cleared.

// File: rtl/tvsnd_i2c_pkg.sv
package tvsnd_i2c_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ADDR_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_SKIP
   } bus_state_t;

   // Strap decode: the strap input picks one of three bus addresses.
   function automatic logic [ADDR_W-1:0] strap_addr(
      input logic [1:0]        sel,
      input logic [ADDR_W-1:0] a_float,
      input logic [ADDR_W-1:0] a_high,
      input logic [ADDR_W-1:0] a_low
   );
      case (sel)
         2'b01:   return a_high;
         2'b10:   return a_low;
         default: return a_float;
      endcase
   endfunction

   // A byte is storable when the test bit is clear and the mode code is legal.
   function automatic logic byte_legal(input logic [BYTE_W-1:0] b);
      return (b[BYTE_W-1] == 1'b0) && (b[1:0] != 2'b11);
   endfunction

endpackage

// File: rtl/tvsnd_i2c_sync.sv
module tvsnd_i2c_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("tvsnd_i2c_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/tvsnd_i2c_engine.sv
module tvsnd_i2c_engine
   import tvsnd_i2c_pkg::*;
#(
   parameter int unsigned BITS = BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [BITS-1:0]   status,
   output logic              sda_pull,
   output logic              wr_stb,
   output logic [BITS-1:0]   wr_byte
);

   localparam int unsigned CNT_W = $clog2(BITS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS);

   generate
      if (BITS != ADDR_W + 1) begin : g_bad
         $error("tvsnd_i2c_engine: BITS must equal address width plus one");
      end
   endgenerate

   bus_state_t     st;
   logic           scl_q, sda_q;
   logic [CNT_W-1:0] cnt;
   logic [BITS-1:0]  sh;

   logic scl_rise, scl_fall, start_c, stop_c;

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         sh       <= '0;
         sda_pull <= 1'b0;
         wr_stb   <= 1'b0;
         wr_byte  <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (start_c) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
         end else if (stop_c) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sda_pull <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_WDATA: begin
                  if (scl_rise && cnt != LAST) begin
                     sh  <= {sh[BITS-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     cnt <= '0;
                     if (st == ST_WDATA) begin
                        sda_pull <= 1'b1;
                        st       <= ST_WDATA_ACK;
                     end else if (sh[BITS-1:1] == own_addr) begin
                        sda_pull <= 1'b1;
                        st       <= ST_ADDR_ACK;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (sh[0]) begin
                        st       <= ST_RDATA;
                        sda_pull <= ~status[BITS-1];
                        sh       <= {status[BITS-2:0], 1'b0};
                     end else begin
                        st       <= ST_WDATA;
                        sda_pull <= 1'b0;
                     end
                  end
               end
               ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     wr_stb   <= 1'b1;
                     wr_byte  <= sh;
                     st       <= ST_SKIP;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise && cnt != LAST) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_pull <= 1'b0;
                        cnt      <= '0;
                        st       <= ST_RACK;
                     end else begin
                        sda_pull <= ~sh[BITS-1];
                        sh       <= {sh[BITS-2:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_fall) st <= ST_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/tvsnd_i2c_regs.sv
module tvsnd_i2c_regs
   import tvsnd_i2c_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RESET_VAL = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_byte,
   output logic [BYTE_W-1:0] ctrl,
   output logic              init_flag
);

   generate
      if (!byte_legal(RESET_VAL)) begin : g_bad
         $error("tvsnd_i2c_regs: RESET_VAL must be a legal control byte");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= RESET_VAL;
         init_flag <= 1'b1;
      end else if (wr_stb && byte_legal(wr_byte)) begin
         ctrl      <= wr_byte;
         init_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/tvsnd_i2c_ctrl.sv
module tvsnd_i2c_ctrl
   import tvsnd_i2c_pkg::*;
#(
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ADDR_FLOAT  = 7'h40,
   parameter logic [ADDR_W-1:0] ADDR_HIGH   = 7'h42,
   parameter logic [ADDR_W-1:0] ADDR_LOW    = 7'h50,
   parameter logic [BYTE_W-1:0] RESET_VAL   = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] adsel,
   input  logic       stereo_det,
   input  logic       biling_det,
   output logic       sda_pull,
   output logic [1:0] mode_sel,
   output logic       force_mono,
   output logic       mute_on,
   output logic       ext_in_sel,
   output logic       refclk_en,
   output logic       baseband_sel
);

   localparam int unsigned FLAG_POS = BYTE_W - 3;

   generate
      if (ADDR_FLOAT == ADDR_HIGH || ADDR_FLOAT == ADDR_LOW || ADDR_HIGH == ADDR_LOW) begin : g_bad
         $error("tvsnd_i2c_ctrl: strap addresses must be distinct");
      end
   endgenerate

   logic              scl_s, sda_s;
   logic              wr_stb;
   logic [BYTE_W-1:0] wr_byte;
   logic [BYTE_W-1:0] ctrl_q;
   logic              init_flag;
   logic [BYTE_W-1:0] status;
   logic [ADDR_W-1:0] own_addr;

   tvsnd_i2c_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s));

   tvsnd_i2c_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s));

   assign own_addr = strap_addr(adsel, ADDR_FLOAT, ADDR_HIGH, ADDR_LOW);

   always_comb begin
      status                  = '0;
      status[BYTE_W-1]        = stereo_det;
      status[BYTE_W-2]        = biling_det;
      status[FLAG_POS]        = init_flag;
   end

   tvsnd_i2c_engine #(.BITS(BYTE_W)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .own_addr (own_addr),
      .status   (status),
      .sda_pull (sda_pull),
      .wr_stb   (wr_stb),
      .wr_byte  (wr_byte)
   );

   tvsnd_i2c_regs #(.RESET_VAL(RESET_VAL)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_byte   (wr_byte),
      .ctrl      (ctrl_q),
      .init_flag (init_flag)
   );

   assign mode_sel     = ctrl_q[1:0];
   assign force_mono   = ctrl_q[2];
   assign mute_on      = ctrl_q[3];
   assign ext_in_sel   = ctrl_q[4];
   assign refclk_en    = ctrl_q[5];
   assign baseband_sel = ctrl_q[6];

endmodule

// File: rtl/tvsnd_i2c_ctrl_chk.sv
module tvsnd_i2c_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_pull,
   input logic [1:0] mode_sel,
   input logic       wr_stb,
   input logic [7:0] ctrl_q,
   input logic       init_flag
);

   AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s); // R3

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel != 2'b11); // R6

   AST_TEST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[7]); // R6

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(ctrl_q)); // R5

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !init_flag |=> !init_flag); // R8

   AST_FLAG_WITH_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (init_flag && !wr_stb) |=> init_flag); // R8

endmodule

bind tvsnd_i2c_ctrl tvsnd_i2c_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .sda_pull  (sda_pull),
   .mode_sel  (mode_sel),
   .wr_stb    (wr_stb),
   .ctrl_q    (ctrl_q),
   .init_flag (init_flag)
);

// File: tb/tvsnd_i2c_ctrl_bench.sv
module tvsnd_i2c_ctrl_bench;

   localparam int Q = 10; // system clocks per quarter serial bit

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [1:0] adsel = 2'b00;
   logic       stereo_det = 1'b0;
   logic       biling_det = 1'b0;
   logic       sda_pull;
   logic [1:0] mode_sel;
   logic       force_mono, mute_on, ext_in_sel, refclk_en, baseband_sel;
   logic       sda_bus;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign sda_bus = m_sda & ~sda_pull;

   tvsnd_i2c_ctrl u_tvsnd_i2c_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .adsel(adsel),
      .stereo_det(stereo_det), .biling_det(biling_det), .sda_pull(sda_pull),
      .mode_sel(mode_sel), .force_mono(force_mono), .mute_on(mute_on),
      .ext_in_sel(ext_in_sel), .refclk_en(refclk_en), .baseband_sel(baseband_sel));

   // vector: [17:16] strap, [15:8] written byte, [7:0] expected register after
   localparam logic [17:0] VEC [6] = '{
      {2'b00, 8'h5A, 8'h5A},
      {2'b01, 8'h23, 8'h5A},
      {2'b10, 8'h3C, 8'h3C},
      {2'b00, 8'h81, 8'h3C},
      {2'b01, 8'h7D, 8'h7D},
      {2'b11, 8'h00, 8'h00}
   };

   function automatic logic [6:0] addr_of(input logic [1:0] s);
      case (s)
         2'b01:   return 7'h42;
         2'b10:   return 7'h50;
         default: return 7'h40;
      endcase
   endfunction

   task automatic wait_q(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] outs();
      return {1'b0, baseband_sel, refclk_en, ext_in_sel, mute_on, force_mono, mode_sel};
   endfunction

   task automatic bus_start();
      m_sda = 1'b1; wait_q(1);
      scl = 1'b1; wait_q(1);
      m_sda = 1'b0; wait_q(1);
      scl = 1'b0; wait_q(1);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_q(1);
      scl = 1'b1; wait_q(1);
      m_sda = 1'b1; wait_q(2);
   endtask

   task automatic bus_bit(input logic b, output logic seen);
      m_sda = b; wait_q(1);
      scl = 1'b1; wait_q(1);
      seen = sda_bus; wait_q(1);
      scl = 1'b0; wait_q(1);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
      bus_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic get_byte(output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         v[i] = s;
      end
      bus_bit(1'b1, s); // master NACK
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                           output logic aa, output logic da);
      bus_start();
      send_byte({a, 1'b0}, aa);
      send_byte(d, da);
      bus_stop();
      wait_q(1);
   endtask

   task automatic do_read(input logic [6:0] a, output logic aa, output logic [7:0] v);
      bus_start();
      send_byte({a, 1'b1}, aa);
      get_byte(v);
      bus_stop();
      wait_q(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic aa, da;
      logic [7:0] rv;
      logic s;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wait_q(2);

      // R4 reset state
      check("R4 reset outputs", outs(), 8'h01);
      check("R3 released after reset", {7'b0, sda_pull}, 8'h00);

      // R7 R8 status read in initial state
      stereo_det = 1'b1; biling_det = 1'b0;
      do_read(7'h40, aa, rv);
      check("R2 read address ack", {7'b0, aa}, 8'h01);
      check("R7 R8 initial status", rv, 8'hA0);

      // R6 R8: rejected write before any stored write keeps the flag set
      do_write(7'h40, 8'h83, aa, da);
      check("R6 illegal byte acked", {7'b0, da}, 8'h01);
      check("R6 illegal byte not stored", outs(), 8'h01);
      stereo_det = 1'b0; biling_det = 1'b1;
      do_read(7'h40, aa, rv);
      check("R8 flag kept after rejected write", rv, 8'h60);

      // R1 R2 R4 R6 vector walk
      for (int k = 0; k < 6; k++) begin
         adsel = VEC[k][17:16];
         do_write(addr_of(VEC[k][17:16]), VEC[k][15:8], aa, da);
         check($sformatf("R1 address ack vec%0d", k), {7'b0, aa}, 8'h01);
         check($sformatf("R2 data ack vec%0d", k), {7'b0, da}, 8'h01);
         check($sformatf("R4 R6 outputs vec%0d", k), outs(), VEC[k][7:0]);
      end

      // R8 flag cleared after stored writes
      adsel = 2'b10;
      stereo_det = 1'b1; biling_det = 1'b1;
      do_read(7'h50, aa, rv);
      check("R7 R8 status after writes", rv, 8'hC0);

      // R9 wrong address: no ack, byte ignored
      adsel = 2'b01;
      do_write(7'h40, 8'h12, aa, da);
      check("R9 no address ack", {7'b0, aa}, 8'h00);
      check("R9 no data ack", {7'b0, da}, 8'h00);
      check("R9 register untouched", outs(), 8'h00);

      // R5 partial byte then stop
      bus_start();
      send_byte({7'h42, 1'b0}, aa);
      for (int i = 7; i >= 3; i--) bus_bit(1'b1, s);
      bus_stop();
      wait_q(1);
      check("R5 partial ack on address", {7'b0, aa}, 8'h01);
      check("R5 partial byte discarded", outs(), 8'h00);

      // R10 repeated start mid address phase, then full write
      bus_start();
      bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s);
      bus_start();
      send_byte({7'h42, 1'b0}, aa);
      send_byte(8'h6E, da);
      bus_stop();
      wait_q(1);
      check("R10 address ack after restart", {7'b0, aa}, 8'h01);
      check("R10 write after restart", outs(), 8'h6E);

      // R1 strap low does not answer the floating address
      adsel = 2'b10;
      do_read(7'h40, aa, rv);
      check("R1 R9 other strap not acked", {7'b0, aa}, 8'h00);
      check("R3 bus released at end", {7'b0, sda_pull}, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule